// File: doc/BRIEF.md
# Flash Power-State Controller

This block decides the power state of a parallel flash memory device. It watches the asynchronous reset/power-down pin, the two active-low chip-enable inputs and the address bus. From these it selects one of four operating conditions: active, automatic power saving, standby or deep power-down. It reports the selection as a 2-bit mode code.

Entering deep power-down aborts the write state machine and clears the status registers. The block does this by issuing one-cycle strobes. After the pin is released, a timed recovery window holds the output-valid flag low before the array outputs may be used again. The recovery length is a cycle count computed from the clock frequency and a time in nanoseconds. The idle threshold for power saving is a parameter.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: A low level on `pd_n_in` sets `mode_o` to 2'b11 (deep power-down) on the third rising clock edge after the pin is seen low, whatever the previous mode. The pin passes through a two-flop synchronizer first.
- R2: On entry to deep power-down from any other internal state, `wsm_abort_o` pulses high for exactly one cycle, in the same cycle that `mode_o` first reads 2'b11. The pulse does not repeat while the pin stays low, and no pulse follows the synchronous reset.
- R3: `stat_clr_o` pulses in exactly the same cycles as `wsm_abort_o`.
- R4: After the synchronized pin returns high, `mode_o` keeps reading 2'b11 and `out_valid_o` stays low for a further REC_CYC = ceil(REC_NS*CLK_MHZ/1000) cycles of recovery. The state then follows R5 to R7.
- R5: Outside deep power-down and recovery, if either `ce0_n` or `ce1_n` is high, `mode_o` is 2'b10 (standby) and `out_valid_o` is low.
- R6: While both chip enables are low, `mode_o` becomes 2'b01 (power saving) once `addr` has been sampled unchanged on IDLE_CYC consecutive edges. It stays 2'b01 while the address holds, and `out_valid_o` is high.
- R7: While enabled, any edge that samples an address different from the previous one gives `mode_o` = 2'b00 (active) and `out_valid_o` high in the following cycle.
- R8: During and after the synchronous reset `rst`, `mode_o` is 2'b11, both strobes are low, `out_valid_o` is low, and the synchronizer holds a low value, so a recovery follows.
- R9: A low pin during the recovery window aborts the recovery. It issues a new strobe pair, and a full recovery window restarts after the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_in | input | 1 | Asynchronous reset/power-down pin, low = power down |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| addr | input | AW | Address bus |
| mode_o | output | 2 | 00 active, 01 power saving, 10 standby, 11 deep power-down |
| wsm_abort_o | output | 1 | One-cycle abort/reset strobe to the write state machine |
| stat_clr_o | output | 1 | One-cycle clear strobe to the status registers |
| out_valid_o | output | 1 | Data outputs may be used |

## Verification
The hardest condition to reach from the ports is a power-down request that arrives inside the recovery window. The same holds for one arriving on the very edge where recovery ends. Both require the pin to drop a precise number of cycles after its release. Directed sequences drop the pin mid-recovery and one cycle before the window closes. The random phase toggles the pin with a low probability, so that some releases are cut short. A fixed address held across a recovery exit makes the block go straight to power saving. That path is also driven on purpose.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    MODE_ACT  = 2'b00,
    MODE_APS  = 2'b01,
    MODE_STBY = 2'b10,
    MODE_DPD  = 2'b11
  } pmode_e;

  typedef enum logic [2:0] {
    S_DPD   = 3'd0,
    S_RECOV = 3'd1,
    S_ACT   = 3'd2,
    S_APS   = 3'd3,
    S_STBY  = 3'd4
  } pstate_e;

  function automatic pmode_e state_to_mode(pstate_e s);
    case (s)
      S_ACT:   return MODE_ACT;
      S_APS:   return MODE_APS;
      S_STBY:  return MODE_STBY;
      default: return MODE_DPD;
    endcase
  endfunction
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fpc_idle_det.sv
module fpc_idle_det #(
  parameter int AW       = 20,
  parameter int IDLE_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic          idle
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] run_q;
  logic [CW:0]   run_nx;
  logic          same;

  assign same   = (addr == addr_q);
  assign run_nx = same ? ({1'b0, run_q} + 1'b1) : '0;
  assign idle   = (run_nx >= {1'b0, LIMIT});

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      run_q  <= '0;
    end else begin
      addr_q <= addr;
      run_q  <= idle ? LIMIT : run_nx[CW-1:0];
    end
  end
endmodule

// File: rtl/fpc_recov_timer.sv
module fpc_recov_timer #(
  parameter int REC_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
    else                  cnt <= '0;
  end
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter int AW       = 20,
  parameter int IDLE_CYC = 8,
  parameter int CLK_MHZ  = 100,
  parameter int REC_NS   = 400,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_n_in,
  input  logic          ce0_n,
  input  logic          ce1_n,
  input  logic [AW-1:0] addr,
  output logic [1:0]    mode_o,
  output logic          wsm_abort_o,
  output logic          stat_clr_o,
  output logic          out_valid_o
);
  localparam int REC_CYC_RAW = (REC_NS * CLK_MHZ + 999) / 1000;
  localparam int REC_CYC     = (REC_CYC_RAW < 1) ? 1 : REC_CYC_RAW;

  pstate_e st, st_nx, op_sel;
  logic    pd_s, idle, rec_done, rec_run, enter_dpd;

  fpc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(pd_n_in), .q(pd_s)
  );

  fpc_idle_det #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .addr(addr), .idle(idle)
  );

  assign rec_run = (st == S_RECOV) && pd_s;

  fpc_recov_timer #(.REC_CYC(REC_CYC)) u_rec (
    .clk(clk), .rst(rst), .run(rec_run), .done(rec_done)
  );

  always_comb begin
    if (ce0_n || ce1_n) op_sel = S_STBY;
    else if (idle)      op_sel = S_APS;
    else                op_sel = S_ACT;
  end

  always_comb begin
    st_nx     = st;
    enter_dpd = 1'b0;
    if (!pd_s) begin
      st_nx     = S_DPD;
      enter_dpd = (st != S_DPD);
    end else begin
      case (st)
        S_DPD:   st_nx = S_RECOV;
        S_RECOV: if (rec_done) st_nx = op_sel;
        default: st_nx = op_sel;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_DPD;
      mode_o      <= MODE_DPD;
      out_valid_o <= 1'b0;
      wsm_abort_o <= 1'b0;
      stat_clr_o  <= 1'b0;
    end else begin
      st          <= st_nx;
      mode_o      <= state_to_mode(st_nx);
      out_valid_o <= (st_nx == S_ACT) || (st_nx == S_APS);
      wsm_abort_o <= enter_dpd;
      stat_clr_o  <= enter_dpd;
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          pd_s,
  input logic          ce0_n,
  input logic          ce1_n,
  input logic [AW-1:0] addr,
  input logic [1:0]    mode_o,
  input logic          wsm_abort_o,
  input logic          stat_clr_o,
  input logic          out_valid_o
);
  p_pd_forces_dpd_r1: assert property (@(posedge clk) disable iff (rst)
    !pd_s |=> mode_o == 2'b11);

  p_abort_in_dpd_r2: assert property (@(posedge clk) disable iff (rst)
    wsm_abort_o |-> mode_o == 2'b11);

  p_abort_single_r2: assert property (@(posedge clk) disable iff (rst)
    wsm_abort_o |=> !wsm_abort_o);

  p_clear_pairs_abort_r3: assert property (@(posedge clk) disable iff (rst)
    wsm_abort_o == stat_clr_o);

  p_no_valid_in_dpd_r4: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'b11 |-> !out_valid_o);

  p_standby_r5: assert property (@(posedge clk) disable iff (rst)
    (pd_s && mode_o != 2'b11 && (ce0_n || ce1_n)) |=> (mode_o == 2'b10 && !out_valid_o));

  p_aps_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pd_s && mode_o == 2'b01 && !ce0_n && !ce1_n && addr == $past(addr)) |=> mode_o == 2'b01);

  p_addr_wakes_r7: assert property (@(posedge clk) disable iff (rst)
    (pd_s && mode_o != 2'b11 && !ce0_n && !ce1_n && addr != $past(addr)) |=> (mode_o == 2'b00 && out_valid_o));
endmodule

bind flash_pwr_ctrl fpc_checker #(.AW(AW)) u_fpc_checker (
  .clk(clk), .rst(rst), .pd_s(pd_s), .ce0_n(ce0_n), .ce1_n(ce1_n),
  .addr(addr), .mode_o(mode_o), .wsm_abort_o(wsm_abort_o),
  .stat_clr_o(stat_clr_o), .out_valid_o(out_valid_o)
);

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
  localparam int AW = 20, IDLE = 8, MHZ = 200, RNS = 400;
  localparam int REC = (RNS * MHZ + 999) / 1000;
  localparam int ST_DPD = 0, ST_REC = 1, ST_ACT = 2, ST_APS = 3, ST_STB = 4;

  logic clk = 0, rst = 1, pd_n = 0, ce0_n = 1, ce1_n = 1;
  logic [AW-1:0] addr = '0;
  logic [1:0] mode_o;
  logic abort_o, clr_o, valid_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_pwr_ctrl #(.AW(AW), .IDLE_CYC(IDLE), .CLK_MHZ(MHZ), .REC_NS(RNS)) i_flash_pwr_ctrl (
    .clk(clk), .rst(rst), .pd_n_in(pd_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .addr(addr),
    .mode_o(mode_o), .wsm_abort_o(abort_o), .stat_clr_o(clr_o), .out_valid_o(valid_o));

  // reference model from the requirements
  logic m_s1, m_s2, m_abort, m_valid, m_left_rec;
  logic [1:0] m_mode;
  logic [AW-1:0] m_aq;
  int m_st, m_rc, m_ic;

  function automatic logic [1:0] code_of(int s);
    case (s)
      ST_ACT: return 2'b00;
      ST_APS: return 2'b01;
      ST_STB: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  always @(posedge clk) begin
    int run, nst, op;
    logic ab;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= ST_DPD; m_rc <= 0; m_ic <= 0; m_aq <= '0;
      m_mode <= 2'b11; m_abort <= 0; m_valid <= 0; m_left_rec <= 0;
    end else begin
      run = (addr == m_aq) ? m_ic + 1 : 0;
      op = (ce0_n || ce1_n) ? ST_STB : (run >= IDLE) ? ST_APS : ST_ACT;
      nst = m_st; ab = 0;
      if (!m_s2) begin nst = ST_DPD; ab = (m_st != ST_DPD); end
      else if (m_st == ST_DPD) nst = ST_REC;
      else if (m_st == ST_REC) begin if (m_rc == REC - 1) nst = op; end
      else nst = op;
      m_rc <= (m_st == ST_REC && m_s2 && m_rc != REC - 1) ? m_rc + 1 : 0;
      m_ic <= (run > IDLE) ? IDLE : run;
      m_aq <= addr;
      m_s1 <= pd_n; m_s2 <= m_s1;
      m_left_rec <= (m_st == ST_REC && nst != ST_REC && nst != ST_DPD);
      m_st <= nst; m_mode <= code_of(nst); m_abort <= ab;
      m_valid <= (nst == ST_ACT || nst == ST_APS);
    end
  end

  function automatic string tag_of();
    if (rst) return "R8";
    if (m_left_rec) return "R4";
    case (m_mode)
      2'b11: return "R1";
      2'b10: return "R5";
      2'b01: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag_of(), mode_o, m_mode);
    chk(m_abort ? "R2" : tag_of(), abort_o, m_abort);
    chk("R3", clr_o, m_abort);
    chk(m_mode == 2'b11 ? "R4" : tag_of(), valid_o, m_valid);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic walk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      addr = addr + 1'b1;
    end
  endtask

  int unsigned seed_init;
  int abort_seen;

  initial begin
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    compare_all();                                   // R8 reset state
    chk("R8", mode_o, 2'b11);
    rst = 0; pd_n = 1; ce0_n = 0; ce1_n = 0;
    walk(REC + 6);                                   // R4 recovery then active
    chk("R7", mode_o, 2'b00);
    step(IDLE + 2);                                  // R6 address holds
    chk("R6", mode_o, 2'b01);
    walk(2);                                         // R7 wake
    chk("R7", mode_o, 2'b00);
    ce1_n = 1; step(2);                              // R5
    chk("R5", mode_o, 2'b10);
    ce1_n = 0; pd_n = 0;
    abort_seen = 0;
    for (int i = 0; i < 12; i++) begin               // R2 single pulse while held low
      @(negedge clk); compare_all();
      if (abort_o) abort_seen++;
    end
    chk("R2", abort_seen, 1);
    pd_n = 1; step(2 + REC / 2);                     // R9 drop mid recovery
    pd_n = 0; abort_seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); compare_all();
      if (abort_o) abort_seen++;
    end
    chk("R9", abort_seen, 1);
    pd_n = 1; step(REC + 1);                         // R9 full window restarts
    chk("R9", mode_o, 2'b11);
    step(2);
    chk("R6", mode_o, 2'b01);                        // static address: straight to saving
    pd_n = 0; step(4); pd_n = 1; step(REC);          // release near window end
    pd_n = 0; step(5); pd_n = 1;
    for (int i = 0; i < 6000; i++) begin             // constrained random
      @(negedge clk);
      compare_all();
      if ($urandom_range(0, 299) == 0) pd_n = ~pd_n;
      if ($urandom_range(0, 39) == 0) ce0_n = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 39) == 0) ce1_n = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 5) == 0) addr = AW'($urandom);
      if ($urandom_range(0, 2999) == 0) rst = 1; else rst = 0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule